// File: doc/BRIEF.md
# Four-Channel SPI Transfer Sequencer

This block sequences word transfers for a four-channel SPI master. Each channel owns a configuration register, a status register with receive-full, transmit-empty and end-of-transfer flags, an enable bit, a transmit word and a receive word. A host reaches these through a simple register port. Writing a transmit word, reading a receive word, or turning a channel on makes that channel try a transfer. The attempt either stalls on its flags, completes at once without touching the wire, or hands one word to an abstract exchange port. The exchange port carries the word, its length and the channel number, and it returns the received word through a one-cycle acknowledge.

The block also drives per-channel DMA request levels for transmit and receive. It pulses per-channel transmit-empty and receive-full events, which a surrounding interrupt unit can latch. A module-level single-channel input, together with a per-channel force bit, decides whether a completed attempt really reaches the exchange port. Shifting bits on the serial lines, chip-select timing and clock polarity are handled elsewhere.

Top module: `spi_chan_seq`

## Requirements
- R1: After reset, every channel reads configuration 0x060000, status 0x2, control 0, transmit 0 and receive 0. All DMA requests, events and the exchange request are low.
- R2: Channel n sits at byte address 0x2C + 0x14·n: configuration at +0x0, status at +0x4, control at +0x8, transmit at +0xC and receive at +0x10. The configuration register keeps only bits 22:0 of a write. Unmapped reads return 0.
- R3: Writes to a status or receive address change nothing.
- R4: A transmit write stores the word, clears transmit-empty (status bit 1) and starts an attempt. An attempt on a channel whose enable (control bit 0) is clear changes no flag and issues no exchange.
- R5: A control write that sets enable while it was clear starts an attempt.
- R6: An exchange presents xfrLen = WL+1, where WL is configuration bits 11:7. It presents only the low xfrLen bits of the transmit word. The received word is stored with every bit at or above xfrLen cleared.
- R7: When an attempt completes, the transmit word clears and end-of-transfer (status bit 2) and transmit-empty set. Receive-full (status bit 0) also sets unless the mode field, configuration bits 13:12, equals 2. The mode codes are 0 for transmit and receive, 1 for receive only and 2 for transmit only.
- R8: An attempt stalls, with no exchange and no flag change, in two cases. One is receive-full set while the mode is not 2 and turbo (configuration bit 19) is clear. The other is transmit-empty set while the mode is not 1. With turbo set, a full receive word does not stall.
- R9: When singleMode is high and force (configuration bit 20) is clear, a non-stalled attempt completes with the R7 flag updates but raises no exchange and leaves the receive word unchanged. With force set, the exchange is issued.
- R10: A receive read returns the stored word, clears receive-full and starts an attempt.
- R11: txDmaReq[n] is high when enable, configuration bit 14 and transmit-empty are all set and the mode is not 1. rxDmaReq[n] is high when enable, configuration bit 15 and receive-full are all set and the mode is not 2.
- R12: In the cycle after an enabled attempt stalls or completes, rxFullEvt[n] pulses for one cycle if receive-full is set, the mode is not 2 and turbo is clear. In that same cycle txEmptyEvt[n] pulses if transmit-empty is set and the mode is not 1.
- R13: Only one exchange is outstanding at a time. xfrReq and xfrChan hold until xfrAck. Attempts made meanwhile wait. When the port frees up, the lowest-numbered waiting channel goes first, and xfrReq is low for the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| singleMode | input | 1 | Module single-channel mode; suppresses exchanges on channels without force |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects apply at the edge) |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| xfrReq | output | 1 | Exchange request, held until acknowledged |
| xfrChan | output | 2 | Channel owning the exchange |
| xfrWord | output | 32 | Transmit word, masked to xfrLen bits |
| xfrLen | output | 6 | Word length in bits (1 to 32) |
| xfrAck | input | 1 | One-cycle exchange acknowledge |
| xfrRxWord | input | 32 | Received word, valid with xfrAck |
| txDmaReq | output | 4 | Per-channel transmit DMA request |
| rxDmaReq | output | 4 | Per-channel receive DMA request |
| txEmptyEvt | output | 4 | Per-channel transmit-empty event pulse |
| rxFullEvt | output | 4 | Per-channel receive-full event pulse |

## Verification
The bench targets the stall rules. A design that ignored turbo or the mode field would start an exchange while an unread word sits in the receive register, or it would hang a receive-only channel on its transmit flag. Transmit-only mode and single-channel mode without force are checked for flags and events with no exchange, where a wrong design would set receive-full or touch the port. Attempts made during an outstanding exchange are queued on two channels at once. This catches a design that drops a queued attempt or lets a higher channel go before a lower one. Word-length masking is checked on both directions with lengths 8 and 16, where an unmasked design leaks upper bits.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  // Register map layout (byte addresses)
  localparam int REG_BASE  = 'h2C;
  localparam int CH_STRIDE = 'h14;
  localparam int OFF_CONF  = 'h0;
  localparam int OFF_STAT  = 'h4;
  localparam int OFF_CTRL  = 'h8;
  localparam int OFF_TX    = 'hC;
  localparam int OFF_RX    = 'h10;

  // Configuration fields
  localparam int CONF_W    = 23;
  localparam logic [CONF_W-1:0] CONF_RST = 23'h060000;
  localparam int WL_LO     = 7;
  localparam int WL_W      = 5;
  localparam int MODE_LO   = 12;
  localparam int TXDMA_BIT = 14;
  localparam int RXDMA_BIT = 15;
  localparam int TURBO_BIT = 19;
  localparam int FORCE_BIT = 20;

  // Mode codes
  localparam logic [1:0] MODE_RX_ONLY = 2'd1;
  localparam logic [1:0] MODE_TX_ONLY = 2'd2;

  // Channel state seen by the sequencer
  typedef struct packed {
    logic       en;
    logic       txEmpty;
    logic       rxFull;
    logic [1:0] mode;
    logic       turbo;
    logic       forced;
    logic       trig;
  } chanView_t;

  // Strobes from the sequencer to the register datapath
  typedef struct packed {
    logic done;
    logic loadRx;
  } chanStb_t;

endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CH_W   = 2,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  chanStb_t          stb [NUM_CH],
  output chanView_t         view [NUM_CH],
  input  logic [CH_W-1:0]   busyChan,
  input  logic [DATA_W-1:0] xfrRxWord,
  output logic [DATA_W-1:0] xfrWord,
  output logic [LEN_W-1:0]  xfrLen,
  output logic [NUM_CH-1:0] txDmaReq,
  output logic [NUM_CH-1:0] rxDmaReq
);

  logic [DATA_W-1:0] chanRd  [NUM_CH];
  logic [DATA_W-1:0] txMasked[NUM_CH];
  logic [LEN_W-1:0]  lenArr  [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : chanG
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(REG_BASE + CH_STRIDE * g);

    logic [CONF_W-1:0] conf;
    logic              en, txe, rxf, eot;
    logic [DATA_W-1:0] txReg, rxReg, mask;
    logic [LEN_W-1:0]  len;
    logic [1:0]        mode;
    logic selConf, selStat, selCtrl, selTx, selRx;
    logic wrConf, wrCtrl, wrTx, rdRx;

    assign selConf = regAddr == BASE + ADDR_W'(OFF_CONF);
    assign selStat = regAddr == BASE + ADDR_W'(OFF_STAT);
    assign selCtrl = regAddr == BASE + ADDR_W'(OFF_CTRL);
    assign selTx   = regAddr == BASE + ADDR_W'(OFF_TX);
    assign selRx   = regAddr == BASE + ADDR_W'(OFF_RX);

    assign wrConf = regWrEn & selConf;
    assign wrCtrl = regWrEn & selCtrl;
    assign wrTx   = regWrEn & selTx;
    assign rdRx   = regRdEn & selRx;

    assign mode = conf[MODE_LO +: 2];
    assign len  = LEN_W'(conf[WL_LO +: WL_W]) + LEN_W'(1);

    always_comb begin
      if (int'(len) >= DATA_W) mask = '1;
      else                     mask = (DATA_W'(1) << len) - DATA_W'(1);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        conf  <= CONF_RST;
        en    <= 1'b0;
        txe   <= 1'b1;
        rxf   <= 1'b0;
        eot   <= 1'b0;
        txReg <= '0;
        rxReg <= '0;
      end else begin
        // sequencer effects first, host access takes precedence after
        if (stb[g].done) begin
          txReg <= '0;
          eot   <= 1'b1;
          txe   <= 1'b1;
          if (mode != MODE_TX_ONLY) rxf <= 1'b1;
        end
        if (stb[g].loadRx) rxReg <= xfrRxWord & mask;
        if (wrConf) conf <= regWrData[CONF_W-1:0];
        if (wrCtrl) en <= regWrData[0];
        if (wrTx) begin
          txReg <= regWrData;
          txe   <= 1'b0;
        end
        if (rdRx) rxf <= 1'b0;
      end
    end

    assign view[g] = '{
      en:      en,
      txEmpty: txe,
      rxFull:  rxf,
      mode:    mode,
      turbo:   conf[TURBO_BIT],
      forced:  conf[FORCE_BIT],
      trig:    wrTx | rdRx | (wrCtrl & regWrData[0] & ~en)
    };

    assign txDmaReq[g] = en & conf[TXDMA_BIT] & txe & (mode != MODE_RX_ONLY);
    assign rxDmaReq[g] = en & conf[RXDMA_BIT] & rxf & (mode != MODE_TX_ONLY);

    always_comb begin
      chanRd[g] = '0;
      if (selConf)      chanRd[g] = DATA_W'(conf);
      else if (selStat) chanRd[g] = DATA_W'({eot, txe, rxf});
      else if (selCtrl) chanRd[g] = DATA_W'(en);
      else if (selTx)   chanRd[g] = txReg;
      else if (selRx)   chanRd[g] = rxReg;
    end

    assign txMasked[g] = txReg & mask;
    assign lenArr[g]   = len;
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_CH; i++) regRdData |= chanRd[i];
  end

  assign xfrWord = txMasked[busyChan];
  assign xfrLen  = lenArr[busyChan];

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              singleMode,
  input  chanView_t         view [NUM_CH],
  input  logic              xfrAck,
  output chanStb_t          stb [NUM_CH],
  output logic              busy,
  output logic [CH_W-1:0]   busyChan,
  output logic [NUM_CH-1:0] txEmptyEvt,
  output logic [NUM_CH-1:0] rxFullEvt
);

  logic [NUM_CH-1:0] pend, stall, evalC, run, wantX, ackHit, doneV;
  logic [NUM_CH-1:0] clearPend, trigV, evRxNext, evTxNext;
  logic              found;
  logic [CH_W-1:0]   startCh;

  always_comb begin
    found   = 1'b0;
    startCh = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      stall[c] = (view[c].rxFull & (view[c].mode != MODE_TX_ONLY) & ~view[c].turbo)
               | (view[c].txEmpty & (view[c].mode != MODE_RX_ONLY));
      evalC[c] = pend[c] & ~busy;
      run[c]   = evalC[c] & view[c].en & ~stall[c];
      wantX[c] = run[c] & (~singleMode | view[c].forced);
      ackHit[c] = busy & xfrAck & (busyChan == CH_W'(c));
      doneV[c]  = (run[c] & ~wantX[c]) | ackHit[c];
      trigV[c]  = view[c].trig;
      if (wantX[c] && !found) begin
        found   = 1'b1;
        startCh = CH_W'(c);
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      clearPend[c] = evalC[c] & ~(wantX[c] & (startCh != CH_W'(c)));
      stb[c].done   = doneV[c];
      stb[c].loadRx = ackHit[c];
      evRxNext[c] = (evalC[c] & view[c].en & stall[c] & view[c].rxFull
                     & (view[c].mode != MODE_TX_ONLY) & ~view[c].turbo)
                  | (doneV[c] & (view[c].mode != MODE_TX_ONLY) & ~view[c].turbo);
      evTxNext[c] = (evalC[c] & view[c].en & stall[c] & view[c].txEmpty
                     & (view[c].mode != MODE_RX_ONLY))
                  | (doneV[c] & (view[c].mode != MODE_RX_ONLY));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= '0;
      busy       <= 1'b0;
      busyChan   <= '0;
      txEmptyEvt <= '0;
      rxFullEvt  <= '0;
    end else begin
      pend       <= (pend & ~clearPend) | trigV;
      txEmptyEvt <= evTxNext;
      rxFullEvt  <= evRxNext;
      if (busy && xfrAck) begin
        busy <= 1'b0;
      end else if (found) begin
        busy     <= 1'b1;
        busyChan <= startCh;
      end
    end
  end

endmodule

// File: rtl/spi_chan_seq.sv
module spi_chan_seq
  import spi_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              singleMode,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              xfrReq,
  output logic [$clog2(NUM_CH)-1:0] xfrChan,
  output logic [DATA_W-1:0] xfrWord,
  output logic [$clog2(DATA_W):0] xfrLen,
  input  logic              xfrAck,
  input  logic [DATA_W-1:0] xfrRxWord,
  output logic [NUM_CH-1:0] txDmaReq,
  output logic [NUM_CH-1:0] rxDmaReq,
  output logic [NUM_CH-1:0] txEmptyEvt,
  output logic [NUM_CH-1:0] rxFullEvt
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int LEN_W = $clog2(DATA_W) + 1;

  chanView_t       view [NUM_CH];
  chanStb_t        stb  [NUM_CH];
  logic            busy;
  logic [CH_W-1:0] busyChan;

  spi_seq_regs #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CH_W(CH_W), .LEN_W(LEN_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .stb(stb), .view(view), .busyChan(busyChan),
    .xfrRxWord(xfrRxWord), .xfrWord(xfrWord), .xfrLen(xfrLen),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  spi_seq_ctrl #(
    .NUM_CH(NUM_CH), .CH_W(CH_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .singleMode(singleMode),
    .view(view), .xfrAck(xfrAck), .stb(stb),
    .busy(busy), .busyChan(busyChan),
    .txEmptyEvt(txEmptyEvt), .rxFullEvt(rxFullEvt)
  );

  assign xfrReq  = busy;
  assign xfrChan = busyChan;

endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk #(
  parameter int DATA_W = 32,
  parameter int CH_W   = 2,
  parameter int LEN_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfrReq,
  input logic              xfrAck,
  input logic [CH_W-1:0]   xfrChan,
  input logic [DATA_W-1:0] xfrWord,
  input logic [LEN_W-1:0]  xfrLen
);

  a_r13_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    xfrReq && !xfrAck |=> xfrReq);

  a_r13_chan_stable: assert property (@(posedge clk) disable iff (!rst_n)
    xfrReq && !xfrAck |=> $stable(xfrChan));

  a_r13_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    xfrReq && xfrAck |=> !xfrReq);

  a_r6_word_fits: assert property (@(posedge clk) disable iff (!rst_n)
    xfrReq |-> (xfrWord >> xfrLen) == '0);

endmodule

bind spi_chan_seq spi_seq_chk #(
  .DATA_W(DATA_W), .CH_W(CH_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xfrReq(xfrReq), .xfrAck(xfrAck),
  .xfrChan(xfrChan), .xfrWord(xfrWord), .xfrLen(xfrLen)
);

// File: tb/spi_chan_seq_bench.sv
module spi_chan_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        singleMode = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        xfrReq;
  logic [1:0]  xfrChan;
  logic [31:0] xfrWord;
  logic [5:0]  xfrLen;
  logic        xfrAck = 1'b0;
  logic [31:0] xfrRxWord = '0;
  logic [3:0]  txDmaReq, rxDmaReq, txEmptyEvt, rxFullEvt;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_chan_seq u_spi_chan_seq (
    .clk(clk), .rst_n(rst_n), .singleMode(singleMode),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .xfrReq(xfrReq), .xfrChan(xfrChan), .xfrWord(xfrWord), .xfrLen(xfrLen),
    .xfrAck(xfrAck), .xfrRxWord(xfrRxWord),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .txEmptyEvt(txEmptyEvt), .rxFullEvt(rxFullEvt)
  );

  // reset read table: {address, expected value}
  localparam logic [39:0] RST_TAB [20] = '{
    {8'h2C, 32'h00060000}, {8'h30, 32'h2}, {8'h34, 32'h0}, {8'h38, 32'h0}, {8'h3C, 32'h0},
    {8'h40, 32'h00060000}, {8'h44, 32'h2}, {8'h48, 32'h0}, {8'h4C, 32'h0}, {8'h50, 32'h0},
    {8'h54, 32'h00060000}, {8'h58, 32'h2}, {8'h5C, 32'h0}, {8'h60, 32'h0}, {8'h64, 32'h0},
    {8'h68, 32'h00060000}, {8'h6C, 32'h2}, {8'h70, 32'h0}, {8'h74, 32'h0}, {8'h78, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic ack(input logic [31:0] w);
    @(negedge clk);
    xfrAck = 1'b1; xfrRxWord = w;
    @(negedge clk);
    xfrAck = 1'b0;
  endtask

  task automatic xfrChk(input string tag, input logic [1:0] ch,
                        input logic [5:0] len, input logic [31:0] word);
    chk({tag, " req"}, 32'(xfrReq), 32'h1);
    chk({tag, " chan"}, 32'(xfrChan), 32'(ch));
    chk({tag, " len"}, 32'(xfrLen), 32'(len));
    chk({tag, " word"}, xfrWord, word);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values at the outputs and through the register map
    chk("R1 dma/evt/req", {txDmaReq, rxDmaReq, txEmptyEvt, rxFullEvt, 15'd0, xfrReq}, 32'h0);
    for (int i = 0; i < 20; i++) begin
      rd(RST_TAB[i][39:32], v);
      chk($sformatf("R1 R2 reset read addr %h", RST_TAB[i][39:32]), v, RST_TAB[i][31:0]);
    end
    rdChk("R2 unmapped read", 8'h10, 32'h0);

    // R2: configuration keeps bits 22:0
    wr(8'h40, 32'hFFFF_FFFF);
    rdChk("R2 conf width", 8'h40, 32'h007F_FFFF);
    wr(8'h40, 32'h0000_0380);

    // R3: status and receive are not writable
    wr(8'h30, 32'h0);
    wr(8'h3C, 32'h55);
    rdChk("R3 status write ignored", 8'h30, 32'h2);
    rdChk("R3 rx write ignored", 8'h3C, 32'h0);

    // R4: transmit write while disabled
    wr(8'h2C, 32'h0000_0380);          // WL=7, mode 0
    wr(8'h38, 32'h0000_ABCD);
    @(negedge clk);
    chk("R4 no req when disabled", 32'(xfrReq), 32'h0);
    chk("R4 no events when disabled", 32'({txEmptyEvt, rxFullEvt}), 32'h0);
    rdChk("R4 txe cleared", 8'h30, 32'h0);
    rdChk("R4 tx stored", 8'h38, 32'h0000_ABCD);

    // R5 R6: enable rising starts an 8-bit exchange
    wr(8'h34, 32'h1);
    @(negedge clk);
    xfrChk("R5 R6 ch0 start", 2'd0, 6'd8, 32'h0000_00CD);
    ack(32'h1234_56F0);
    chk("R13 req drops after ack", 32'(xfrReq), 32'h0);
    chk("R12 events after ch0 done", 32'({txEmptyEvt, rxFullEvt}), 32'h11);
    rdChk("R7 status after done", 8'h30, 32'h7);
    rdChk("R7 tx cleared", 8'h38, 32'h0);

    // R8: full receive word stalls the next transfer
    wr(8'h38, 32'h0000_0F0F);
    @(negedge clk);
    chk("R8 stall no req", 32'(xfrReq), 32'h0);
    chk("R12 stall rx event", 32'({txEmptyEvt, rxFullEvt}), 32'h01);
    // R10: receive read returns word, clears full, restarts
    rdChk("R10 rx masked word", 8'h3C, 32'h0000_00F0);
    @(negedge clk);
    xfrChk("R10 restart after rx read", 2'd0, 6'd8, 32'h0000_000F);
    ack(32'hFFFF_FFA5);
    rdChk("R6 rx masked", 8'h3C, 32'h0000_00A5);

    // R11 R8: channel 2 with DMA enables
    wr(8'h54, 32'h0000_C380);
    chk("R11 tx dma off while disabled", 32'(txDmaReq[2]), 32'h0);
    wr(8'h5C, 32'h1);
    chk("R11 tx dma on", 32'(txDmaReq[2]), 32'h1);
    chk("R11 rx dma off", 32'(rxDmaReq[2]), 32'h0);
    @(negedge clk);
    chk("R8 txe stall no req", 32'(xfrReq), 32'h0);
    chk("R12 tx event on stall", 32'(txEmptyEvt), 32'h4);
    @(negedge clk);
    chk("R12 event is one cycle", 32'({txEmptyEvt, rxFullEvt}), 32'h0);
    wr(8'h54, 32'h0000_D380);          // receive only
    chk("R11 tx dma off in rx-only", 32'(txDmaReq[2]), 32'h0);
    wr(8'h60, 32'h0000_005A);
    @(negedge clk);
    xfrChk("R8 rx-only exchange", 2'd2, 6'd8, 32'h0000_005A);
    ack(32'h0000_013C);
    chk("R12 rx-only events", 32'({txEmptyEvt, rxFullEvt}), 32'h04);
    chk("R11 rx dma on", 32'(rxDmaReq[2]), 32'h1);
    chk("R11 tx dma stays off", 32'(txDmaReq[2]), 32'h0);
    rdChk("R7 rx-only status", 8'h58, 32'h7);

    // R9 R7: single-channel mode without force on a transmit-only channel
    singleMode = 1'b1;
    wr(8'h68, 32'h0000_2780);          // mode 2, WL=15
    wr(8'h74, 32'h0000_1234);
    wr(8'h70, 32'h1);
    @(negedge clk);
    chk("R9 no exchange in single mode", 32'(xfrReq), 32'h0);
    chk("R12 tx-only events", 32'({txEmptyEvt, rxFullEvt}), 32'h80);
    rdChk("R7 tx-only status", 8'h6C, 32'h6);
    rdChk("R9 tx cleared", 8'h74, 32'h0);
    rdChk("R9 rx untouched", 8'h78, 32'h0);

    // R9 R6: force bit lets the exchange through, 16-bit word
    wr(8'h68, 32'h0010_2780);
    wr(8'h74, 32'h00BE_EF12);
    @(negedge clk);
    xfrChk("R9 forced exchange", 2'd3, 6'd16, 32'h0000_EF12);
    ack(32'hFFFF_5678);
    rdChk("R7 tx-only no rx full", 8'h6C, 32'h6);
    rdChk("R6 16-bit rx", 8'h78, 32'h0000_5678);
    singleMode = 1'b0;

    // R13: queued attempts during an exchange, lowest channel first
    wr(8'h4C, 32'h0000_0011);          // ch1 disabled, attempt does nothing
    rdChk("R4 ch1 txe cleared", 8'h44, 32'h0);
    wr(8'h48, 32'h1);
    @(negedge clk);
    xfrChk("R13 ch1 start", 2'd1, 6'd8, 32'h0000_0011);
    wr(8'h38, 32'h0000_0022);
    rdChk("R10 ch0 rx during busy", 8'h3C, 32'h0000_00A5);
    rdChk("R10 ch2 rx during busy", 8'h64, 32'h0000_003C);
    chk("R13 ch1 still owns port", 32'(xfrChan), 32'h1);
    ack(32'h0000_0077);
    chk("R13 gap after ack", 32'(xfrReq), 32'h0);
    @(negedge clk);
    xfrChk("R13 ch0 first", 2'd0, 6'd8, 32'h0000_0022);
    ack(32'h0000_0099);
    @(negedge clk);
    xfrChk("R13 ch2 next", 2'd2, 6'd8, 32'h0000_0000);
    ack(32'h0000_0044);
    rdChk("R13 ch1 rx", 8'h50, 32'h0000_0077);
    rdChk("R13 ch0 rx", 8'h3C, 32'h0000_0099);

    // R11 R4: disabling drops DMA; a receive read then starts nothing
    wr(8'h5C, 32'h0);
    chk("R11 rx dma off after disable", 32'(rxDmaReq[2]), 32'h0);
    rdChk("R5 ctrl reads zero", 8'h5C, 32'h0);
    rdChk("R10 ch2 rx", 8'h64, 32'h0000_0044);
    @(negedge clk);
    chk("R4 disabled attempt no req", 32'(xfrReq), 32'h0);
    rdChk("R4 disabled attempt flags", 8'h58, 32'h6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule